// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept, based on its 48-bit destination address. The address bytes arrive one per accepted strobe, in wire order, with the first byte marked. While they arrive, the block stores the address and advances a CRC-32 over it one byte at a time.

One cycle after the sixth byte, the block raises a one-cycle decision strobe. With it come a pass bit and a filter-fail bit. The decision draws on several sources:

- a bank of exact-match unicast entries, each with its own enable;
- a 64-bin multicast hash table, split across two 32-bit words;
- a pass-all-multicast mode;
- a promiscuous mode;
- a broadcast block bit;
- a receive-all mode, used for debug.

The receiver's frame buffer uses the pass bit to keep or discard the frame. The fail bit goes into the frame's receive status.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, `decisionValid`, `framePass` and `daFilterFail` are 0. They stay 0 until a complete address has been received.
- R2: A byte with `byteValid` and `byteFirst` both high starts a new address as byte 0, even if an earlier address is unfinished. Each later `byteValid` cycle adds the next byte, and idle cycles may occur between bytes. `decisionValid` is high for exactly one cycle: the cycle right after the one that carries byte 5. Valid bytes that follow byte 5 without `byteFirst` are ignored and raise no decision.
- R3: The hash index is built from a CRC-32 over the 48 address bits, taken least significant bit of byte 0 first. The CRC uses reflected polynomial 0xEDB88320, starts at all ones, and is not complemented at the end. Call the resulting register C. Then bit (5-k) of the 6-bit index equals the complement of C bit k, for k = 0 to 5.
- R4: Index bit 5 selects the word: 1 selects `hashHi`, 0 selects `hashLo`. Index bits 4:0 select the bit within that word.
- R5: An address is multicast when bit 0 of byte 0 is 1. A multicast address that is not broadcast, seen with `hashMcastEn` set and `passAllMcastEn` clear, passes only if its selected hash bit is 1.
- R6: With `passAllMcastEn` set, every multicast address passes, whatever the hash table holds.
- R7: With `promiscEn` set, every address passes and `daFilterFail` is 0.
- R8: Entry e of the unicast table sits in bits `ucastTable[48*e+47:48*e]`, with byte 0 in the low 8 bits. Outside promiscuous mode, a unicast address passes only if it equals an entry whose `ucastEnable[e]` bit is 1. Entries with a clear enable bit never match.
- R9: The broadcast address (all ones) passes unless `bcastBlockEn` is set. Promiscuous mode overrides the block bit.
- R10: With `recvAllEn` set, `framePass` is always 1. `daFilterFail` still reports whether the address would have been rejected.
- R11: A multicast address seen with neither hash mode nor pass-all mode passes only on an enabled exact-match entry, and the hash table has no effect on it. In every mode, `daFilterFail` is 1 exactly when the address is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Address byte strobe |
| byteFirst | input | 1 | Marks byte 0 of an address |
| byteData | input | 8 | Address byte, wire order |
| promiscEn | input | 1 | Pass every frame |
| recvAllEn | input | 1 | Forward all frames, keep fail flag |
| passAllMcastEn | input | 1 | Pass every multicast frame |
| hashMcastEn | input | 1 | Filter multicast through the hash table |
| bcastBlockEn | input | 1 | Reject broadcast |
| hashLo | input | 32 | Hash bins 0 to 31 |
| hashHi | input | 32 | Hash bins 32 to 63 |
| ucastTable | input | NUM_UC*48 | Exact-match entries |
| ucastEnable | input | NUM_UC | Per-entry enable |
| decisionValid | output | 1 | One-cycle decision strobe |
| framePass | output | 1 | Keep the frame |
| daFilterFail | output | 1 | Address would be rejected |

## Verification
The bench sweeps pseudo-random multicast addresses against complementary hash tables and against one-hot tables. These sweeps expose a design that picks the wrong word, reverses the index, or skips the complement: such a design reads a different bin. Each table entry is tried with its enable bit on and off, which catches a comparator that ignores the enable or places byte 0 wrongly. Further cases cover:

- a restart in the middle of an address;
- idle gaps between bytes;
- trailing bytes after byte 5, where a miscounting controller would fire a second decision or decide on the wrong bytes;
- broadcast with and without the block bit;
- promiscuous and receive-all modes, where the fail flag must still report rejection correctly.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_BITS = ADDR_BYTES * 8;
  localparam int HASH_IDX_W = 6;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // store byteData this cycle
    logic seed;        // start CRC from all ones
    logic [2:0] slot;  // byte position within address
  } dafStrobe_t;

  // One byte of reflected CRC-32, bit 0 first
  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic byteValid,
  input  logic byteFirst,
  output dafStrobe_t strb,
  output logic decisionValid
);
  localparam logic [2:0] LAST_SLOT = 3'(ADDR_BYTES - 1);
  localparam logic [2:0] DONE_CNT = 3'(ADDR_BYTES);

  logic [2:0] cnt;
  logic doneQ;

  always_comb begin
    strb = '0;
    if (byteValid && byteFirst) begin
      strb.capture = 1'b1;
      strb.seed = 1'b1;
      strb.slot = 3'd0;
    end else if (byteValid && cnt != 3'd0 && cnt < DONE_CNT) begin
      strb.capture = 1'b1;
      strb.slot = cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= 3'd0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strb.capture && (strb.slot == LAST_SLOT);
      if (strb.capture) cnt <= strb.slot + 3'd1;
    end
  end

  assign decisionValid = doneQ;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid); // R2
  AST_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |-> $past(byteValid)); // R2
endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
#(
  parameter int NUM_UC = 16
) (
  input  logic clk,
  input  logic rstN,
  input  dafStrobe_t strb,
  input  logic decisionValid,
  input  logic [7:0] byteData,
  input  logic promiscEn,
  input  logic recvAllEn,
  input  logic passAllMcastEn,
  input  logic hashMcastEn,
  input  logic bcastBlockEn,
  input  logic [31:0] hashLo,
  input  logic [31:0] hashHi,
  input  logic [NUM_UC*ADDR_BITS-1:0] ucastTable,
  input  logic [NUM_UC-1:0] ucastEnable,
  output logic framePass,
  output logic daFilterFail
);
  logic [ADDR_BITS-1:0] addrQ;
  logic [31:0] crcQ;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic [NUM_UC-1:0] hitVec;
  logic hashBit, ucHit, isMcast, isBcast, accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      crcQ <= '1;
    end else if (strb.capture) begin
      addrQ[8*strb.slot +: 8] <= byteData;
      crcQ <= crcStep(strb.seed ? 32'hFFFF_FFFF : crcQ, byteData);
    end
  end

  // Complement, reverse, keep top six bits
  always_comb begin
    for (int k = 0; k < HASH_IDX_W; k++) hashIdx[HASH_IDX_W-1-k] = ~crcQ[k];
  end

  assign hashBit = hashIdx[HASH_IDX_W-1] ? hashHi[hashIdx[4:0]] : hashLo[hashIdx[4:0]];

  for (genvar e = 0; e < NUM_UC; e++) begin : gEntry
    assign hitVec[e] = ucastEnable[e] && (ucastTable[e*ADDR_BITS +: ADDR_BITS] == addrQ);
  end

  assign ucHit = |hitVec;
  assign isMcast = addrQ[0];
  assign isBcast = &addrQ;

  always_comb begin
    accept = 1'b0;
    if (promiscEn) accept = 1'b1;
    else if (isBcast) accept = !bcastBlockEn;
    else if (isMcast) begin
      if (passAllMcastEn) accept = 1'b1;
      else if (hashMcastEn) accept = hashBit;
      else accept = ucHit;
    end else accept = ucHit;
  end

  assign framePass = decisionValid && (accept || recvAllEn);
  assign daFilterFail = decisionValid && !accept;

  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && promiscEn) |-> (framePass && !daFilterFail)); // R7
  AST_RECVALL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && recvAllEn) |-> framePass); // R10
  AST_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && !recvAllEn) |-> (framePass != daFilterFail)); // R11
  AST_BCAST_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && isBcast && !bcastBlockEn) |-> framePass); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !decisionValid |-> (!framePass && !daFilterFail)); // R1
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import daf_pkg::*;
#(
  parameter int NUM_UC = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic byteValid,
  input  logic byteFirst,
  input  logic [7:0] byteData,
  input  logic promiscEn,
  input  logic recvAllEn,
  input  logic passAllMcastEn,
  input  logic hashMcastEn,
  input  logic bcastBlockEn,
  input  logic [31:0] hashLo,
  input  logic [31:0] hashHi,
  input  logic [NUM_UC*48-1:0] ucastTable,
  input  logic [NUM_UC-1:0] ucastEnable,
  output logic decisionValid,
  output logic framePass,
  output logic daFilterFail
);
  dafStrobe_t strb;

  daf_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteFirst(byteFirst),
    .strb(strb), .decisionValid(decisionValid)
  );

  daf_datapath #(.NUM_UC(NUM_UC)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .decisionValid(decisionValid),
    .byteData(byteData), .promiscEn(promiscEn), .recvAllEn(recvAllEn),
    .passAllMcastEn(passAllMcastEn), .hashMcastEn(hashMcastEn),
    .bcastBlockEn(bcastBlockEn), .hashLo(hashLo), .hashHi(hashHi),
    .ucastTable(ucastTable), .ucastEnable(ucastEnable),
    .framePass(framePass), .daFilterFail(daFilterFail)
  );
endmodule

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;
  localparam int NUM_UC = 16;
  logic clk = 0, rstN = 0;
  logic byteValid = 0, byteFirst = 0;
  logic [7:0] byteData = 0;
  logic promiscEn = 0, recvAllEn = 0, passAllMcastEn = 0, hashMcastEn = 0, bcastBlockEn = 0;
  logic [31:0] hashLo = 0, hashHi = 0;
  logic [NUM_UC*48-1:0] ucastTable = '0;
  logic [NUM_UC-1:0] ucastEnable = '0;
  logic decisionValid, framePass, daFilterFail;
  int checks = 0, errors = 0;
  logic [63:0] rs = 64'h1234_5678_9ABC_DEF1;

  always #10 clk = ~clk;

  rx_da_filter #(.NUM_UC(NUM_UC)) dut (.*);

  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] c;
    logic [5:0] idx;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ a[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    for (int k = 0; k < 6; k++) idx[5-k] = ~c[k];
    return idx;
  endfunction

  function automatic logic refHash(input logic [47:0] a);
    logic [63:0] tbl;
    tbl = {hashHi, hashLo};
    return tbl[refIdx(a)];
  endfunction

  function automatic logic refAccept(input logic [47:0] a);
    logic hit;
    hit = 0;
    for (int e = 0; e < NUM_UC; e++)
      if (ucastEnable[e] && ucastTable[e*48 +: 48] == a) hit = 1;
    if (promiscEn) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !bcastBlockEn;
    if (a[0]) begin
      if (passAllMcastEn) return 1'b1;
      if (hashMcastEn) return refHash(a);
      return hit;
    end
    return hit;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nextRand(output logic [47:0] v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    v = rs[47:0];
  endtask

  // Drive at negedge; returns at the negedge where the decision is visible
  task automatic sendAddr(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      byteValid = 1; byteFirst = (i == 0); byteData = a[8*i +: 8];
      @(negedge clk);
      byteValid = 0; byteFirst = 0;
      if (i < 5) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic checkAddr(input logic [47:0] a, input int gap, input string tag);
    logic acc;
    sendAddr(a, gap);
    acc = refAccept(a);
    chk(decisionValid === 1'b1, {tag, " valid"}, {7'd0, decisionValid}, 8'd1);
    chk(framePass === (acc | recvAllEn), {tag, " pass"}, {7'd0, framePass}, {7'd0, acc | recvAllEn});
    chk(daFilterFail === !acc, {tag, " fail"}, {7'd0, daFilterFail}, {7'd0, !acc});
    @(negedge clk);
    chk(decisionValid === 1'b0, {tag, " R2 one-cycle"}, {7'd0, decisionValid}, 8'd0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] a;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(decisionValid === 0 && framePass === 0 && daFilterFail === 0, "R1 during reset",
        {5'd0, decisionValid, framePass, daFilterFail}, 8'd0);
    rstN = 1;
    @(negedge clk);
    chk(decisionValid === 0 && framePass === 0 && daFilterFail === 0, "R1 after reset",
        {5'd0, decisionValid, framePass, daFilterFail}, 8'd0);

    // Table: unicast entries, entry 5 multicast
    for (int e = 0; e < NUM_UC; e++) begin
      nextRand(a);
      a[0] = (e == 5);
      ucastTable[e*48 +: 48] = a;
    end
    ucastEnable = 16'b1011_1110_0111_1110;

    // R8 exact match with and without enable
    for (int e = 0; e < NUM_UC; e++) checkAddr(ucastTable[e*48 +: 48], 0, "R8 entry");
    for (int n = 0; n < 20; n++) begin
      nextRand(a); a[0] = 0;
      checkAddr(a, 0, "R8 miss");
    end

    // R11 multicast without hash/pass-all: table ignored, exact entry only
    hashLo = '1; hashHi = '1;
    checkAddr(ucastTable[5*48 +: 48], 0, "R11 mc entry");
    for (int n = 0; n < 10; n++) begin
      nextRand(a); a[0] = 1;
      checkAddr(a, 0, "R11 mc no mode");
    end

    // R3 R5 hash sweep with complementary tables
    hashMcastEn = 1;
    for (int p = 0; p < 2; p++) begin
      hashLo = p ? 32'h3C5A_96E1 : ~32'h3C5A_96E1;
      hashHi = p ? 32'hC0FF_EE12 : ~32'hC0FF_EE12;
      for (int n = 0; n < 80; n++) begin
        nextRand(a); a[0] = 1;
        checkAddr(a, 0, "R3 R5 hash");
      end
    end

    // R4 one-hot: own bin passes, mirrored bin does not
    for (int n = 0; n < 40; n++) begin
      logic [63:0] t;
      nextRand(a); a[0] = 1;
      t = 64'd1 << refIdx(a);
      {hashHi, hashLo} = t;
      checkAddr(a, 1, "R4 onehot own");
      {hashHi, hashLo} = {t[31:0], t[63:32]};
      checkAddr(a, 0, "R4 onehot swap");
    end

    // R6 pass all multicast with empty table
    hashLo = 0; hashHi = 0; passAllMcastEn = 1;
    for (int n = 0; n < 20; n++) begin
      nextRand(a); a[0] = 1;
      checkAddr(a, 0, "R6 pass-all");
    end
    passAllMcastEn = 0;

    // R9 broadcast
    checkAddr(48'hFFFF_FFFF_FFFF, 0, "R9 bcast open");
    bcastBlockEn = 1;
    checkAddr(48'hFFFF_FFFF_FFFF, 0, "R9 bcast block");
    promiscEn = 1;
    checkAddr(48'hFFFF_FFFF_FFFF, 0, "R9 R7 bcast promisc");

    // R7 promiscuous
    for (int n = 0; n < 20; n++) begin
      nextRand(a);
      checkAddr(a, 0, "R7 promisc");
    end
    promiscEn = 0; bcastBlockEn = 0;

    // R10 receive all
    recvAllEn = 1;
    for (int n = 0; n < 10; n++) begin
      nextRand(a); a[0] = 0;
      checkAddr(a, 0, "R10 reject");
    end
    checkAddr(ucastTable[1*48 +: 48], 0, "R10 match");
    recvAllEn = 0;

    // R2 gaps between bytes
    for (int n = 0; n < 8; n++) begin
      nextRand(a);
      checkAddr(a, 3, "R2 gaps");
    end

    // R2 trailing bytes raise no decision
    for (int n = 0; n < 5; n++) begin
      byteValid = 1; byteFirst = 0; byteData = 8'(n + 8'h40);
      @(negedge clk);
      chk(decisionValid === 1'b0, "R2 trailing", {7'd0, decisionValid}, 8'd0);
    end
    byteValid = 0;
    @(negedge clk);
    chk(decisionValid === 1'b0, "R2 trailing end", {7'd0, decisionValid}, 8'd0);

    // R2 restart mid-address: decision on second address only
    for (int i = 0; i < 3; i++) begin
      byteValid = 1; byteFirst = (i == 0); byteData = 8'hA5;
      @(negedge clk);
      chk(decisionValid === 1'b0, "R2 partial", {7'd0, decisionValid}, 8'd0);
    end
    byteValid = 0;
    checkAddr(ucastTable[2*48 +: 48], 0, "R2 restart");
    checkAddr(ucastTable[8*48 +: 48], 0, "R2 restart miss");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule